// File: doc/BRIEF.md
# Processor Condition Register with Guarded Power Flags

This block is the condition byte of a small 8-bit processor core. It holds four arithmetic condition flags (carry, half carry, zero, signed overflow) and two power-management flags (sleep-entered and watchdog-expired). The execution unit updates any subset of the arithmetic flags through a per-flag enable. Software can write the whole byte. Dedicated single-cycle pulses signal power-on reset, a watchdog expiry, the watchdog-clear instruction and the sleep instruction.

The two power flags are shielded from software. A byte write changes only the four arithmetic flags, and the power flags move only on their own events. The register content is always visible on a read port. Bits 6 and 7 read as zero.

Top module: `cond_reg`

## Requirements
- R1: The bit layout is carry at bit 0, half carry at bit 1, zero at bit 2, overflow at bit 3, sleep flag at bit 4 and watchdog flag at bit 5. Bits 6 and 7 of `rd_data` always read 0.
- R2: While `rst_n` is low, or in the cycle after a `por_pulse`, the whole register reads 0x00.
- R3: A software write (`sw_we`) loads `sw_data` bits 3:0 into the arithmetic flags one cycle later and never changes bits 4 and 5.
- R4: An ALU update loads `alu_flags[i]` into arithmetic flag i only where `alu_en[i]` is 1. The other flags keep their value.
- R5: When a software write and an ALU update occur in the same cycle, the ALU value wins for each enabled flag. The software value applies to the flags that are not enabled.
- R6: A `wdt_timeout` pulse sets the watchdog flag. `wdt_clear` or `halt` clears it. When a timeout and a clear occur in the same cycle, the timeout wins.
- R7: `halt` sets the sleep flag, and `wdt_clear` clears it.
- R8: `por_pulse` overrides every other input in the same cycle.
- R9: Without any event, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_pulse | input | 1 | Synchronous power-on clear |
| wdt_timeout | input | 1 | Watchdog expiry event |
| wdt_clear | input | 1 | Watchdog-clear instruction event |
| halt | input | 1 | Sleep instruction event |
| alu_en | input | 4 | Per-flag update enable {ov,z,ac,c} |
| alu_flags | input | 4 | Flag values from the ALU {ov,z,ac,c} |
| sw_we | input | 1 | Software byte write strobe |
| sw_data | input | 8 | Software write data |
| rd_data | output | 8 | Register contents |

## Verification
Every event takes effect at the first rising edge after it is presented, so each result appears on `rd_data` exactly one cycle after its stimulus. The bench drives inputs on the falling edge and samples after the next rising edge. At each sample it compares against a model byte that it advances once per cycle from the same inputs. Reset is checked while `rst_n` is asserted, before any edge.

// File: rtl/cond_reg_pkg.sv
package cond_reg_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned ARITH_W = 4;
  localparam int unsigned BIT_PDF = 4;
  localparam int unsigned BIT_TO  = 5;

  typedef struct packed {
    logic to;
    logic pdf;
  } pwr_flags_t;

  function automatic logic [ARITH_W-1:0] merge_arith(
    input logic [ARITH_W-1:0] cur,
    input logic               we,
    input logic [ARITH_W-1:0] wdat,
    input logic [ARITH_W-1:0] en,
    input logic [ARITH_W-1:0] alu);
    logic [ARITH_W-1:0] base;
    base = we ? wdat : cur;
    return (en & alu) | (~en & base);
  endfunction

  function automatic pwr_flags_t next_pwr(
    input pwr_flags_t cur,
    input logic tmo,
    input logic clr,
    input logic hlt);
    pwr_flags_t n;
    n = cur;
    if (clr || hlt) n.to = 1'b0;
    if (tmo)        n.to = 1'b1;
    if (hlt)        n.pdf = 1'b1;
    if (clr)        n.pdf = 1'b0;
    return n;
  endfunction
endpackage

// File: rtl/cond_arith_flags.sv
module cond_arith_flags
  import cond_reg_pkg::*;
#(
  parameter int unsigned W = ARITH_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         we,
  input  logic [W-1:0] wdat,
  input  logic [W-1:0] en,
  input  logic [W-1:0] alu,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      always_comb nxt[i] = en[i] ? alu[i] : (we ? wdat[i] : q[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else          q <= nxt;
  end
endmodule

// File: rtl/cond_pwr_flags.sv
module cond_pwr_flags
  import cond_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tmo,
  input  logic       wclr,
  input  logic       hlt,
  output pwr_flags_t q
);
  pwr_flags_t nxt;

  always_comb nxt = next_pwr(q, tmo, wclr, hlt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else          q <= nxt;
  end
endmodule

// File: rtl/cond_reg.sv
module cond_reg
  import cond_reg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_pulse,
  input  logic             wdt_timeout,
  input  logic             wdt_clear,
  input  logic             halt,
  input  logic [3:0]       alu_en,
  input  logic [3:0]       alu_flags,
  input  logic             sw_we,
  input  logic [7:0]       sw_data,
  output logic [7:0]       rd_data
);
  logic [ARITH_W-1:0] arith_q;
  pwr_flags_t         pwr_q;
  logic               ev_to_set;
  logic               ev_pdf_set;

  assign ev_to_set  = wdt_timeout & ~por_pulse;
  assign ev_pdf_set = halt & ~wdt_clear & ~por_pulse;

  cond_arith_flags #(.W(ARITH_W)) u_arith (
    .clk(clk), .rst_n(rst_n), .clr(por_pulse), .we(sw_we),
    .wdat(sw_data[ARITH_W-1:0]), .en(alu_en), .alu(alu_flags), .q(arith_q)
  );

  cond_pwr_flags u_pwr (
    .clk(clk), .rst_n(rst_n), .clr(por_pulse), .tmo(wdt_timeout),
    .wclr(wdt_clear), .hlt(halt), .q(pwr_q)
  );

  always_comb begin
    rd_data = '0;
    rd_data[ARITH_W-1:0] = arith_q;
    rd_data[BIT_PDF]     = pwr_q.pdf;
    rd_data[BIT_TO]      = pwr_q.to;
  end
endmodule

// File: rtl/cond_reg_chk.sv
module cond_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       por_pulse,
  input logic       wdt_timeout,
  input logic       wdt_clear,
  input logic       halt,
  input logic [3:0] alu_en,
  input logic [3:0] alu_flags,
  input logic       sw_we,
  input logic [7:0] sw_data,
  input logic [7:0] rd_data,
  input logic       ev_to_set,
  input logic       ev_pdf_set
);
  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:6] == 2'b00);
  a_r8_por_clears: assert property (@(posedge clk) disable iff (!rst_n)
    por_pulse |=> rd_data == 8'h00);
  a_r6_to_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_to_set |=> rd_data[5]);
  a_r7_pdf_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pdf_set |=> rd_data[4]);
  a_r3_sw_keeps_pwr: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !por_pulse && !wdt_timeout && !wdt_clear && !halt)
      |=> $stable(rd_data[5:4]));
  a_r4_alu_c: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en[0] && !por_pulse) |=> rd_data[0] == $past(alu_flags[0]));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_pulse && !wdt_timeout && !wdt_clear && !halt && !sw_we && alu_en == 4'h0)
      |=> $stable(rd_data));
endmodule

bind cond_reg cond_reg_chk u_chk (.*);

// File: tb/cond_reg_tb.sv
module cond_reg_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_pulse = 0, wdt_timeout = 0, wdt_clear = 0, halt = 0, sw_we = 0;
  logic [3:0] alu_en = '0, alu_flags = '0;
  logic [7:0] sw_data = '0;
  logic [7:0] rd_data;
  logic [7:0] model;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  cond_reg u_dut (.*);

  function automatic logic [7:0] predict(input logic [7:0] m,
      input logic por, tmo, clr, hlt, we, input logic [3:0] en, fl,
      input logic [7:0] wd);
    logic [7:0] r;
    if (por) return 8'h00;
    r = m;
    for (int i = 0; i < 4; i++) begin
      if (we) r[i] = wd[i];
      if (en[i]) r[i] = fl[i];
    end
    if (hlt) begin r[4] = 1'b1; r[5] = 1'b0; end
    if (clr) begin r[4] = 1'b0; r[5] = 1'b0; end
    if (tmo) r[5] = 1'b1;
    r[7:6] = 2'b00;
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  task automatic step(input string req, input logic por, tmo, clr, hlt, we,
      input logic [3:0] en, fl, input logic [7:0] wd);
    @(negedge clk);
    por_pulse = por; wdt_timeout = tmo; wdt_clear = clr; halt = hlt;
    sw_we = we; alu_en = en; alu_flags = fl; sw_data = wd;
    model = predict(model, por, tmo, clr, hlt, we, en, fl, wd);
    @(posedge clk); #1;
    check(req, model);
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    model = 8'h00;
    #1; check("R2 reset", 8'h00);
    #10; rst_n = 1'b1;
    step("R3 sw write ignores pwr bits", 0,0,0,0,1, 4'h0,4'h0, 8'hFF);
    step("R7 halt sets sleep, R6 clears wdt", 0,0,0,1,0, 4'h0,4'h0, 8'h00);
    step("R6 timeout sets wdt", 0,1,0,0,0, 4'h0,4'h0, 8'h00);
    step("R9 hold", 0,0,0,0,0, 4'h0,4'h0, 8'h00);
    step("R3 sw write keeps pwr", 0,0,0,0,1, 4'h0,4'h0, 8'hF5);
    step("R6 timeout beats clear", 0,1,1,0,0, 4'h0,4'h0, 8'h00);
    step("R7 clear drops sleep", 0,0,1,0,0, 4'h0,4'h0, 8'h00);
    step("R4 partial alu update", 0,0,0,0,0, 4'h5,4'hF,8'h00);
    step("R5 alu beats sw", 0,0,0,0,1, 4'h3,4'h0, 8'h0F);
    step("R1 layout bits", 0,1,0,1,1, 4'h0,4'h0, 8'hCA);
    step("R8 por overrides all", 1,1,1,1,1, 4'hF,4'hF, 8'hFF);
    step("R2 post-por zero", 0,0,0,0,0, 4'h0,4'h0, 8'h00);
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      step("R1/R3/R4/R5/R6/R7 random", (r[3:0] == 0), r[4]&r[5], r[6]&r[7],
           r[8]&r[9], r[10], r[14:11], r[18:15], r[26:19]);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule